// File: doc/BRIEF.md
# Four-Channel Serial DAC Command Core

This block is the digital side of a four-channel, 10-bit voltage DAC. A host writes 16-bit command words over a three-wire serial port made of a serial clock, an active-low select and a data line. On the rising edge of the select, the core decodes the word's 4-bit opcode. It then updates a two-stage register pair for each channel. The first stage is a staging register. The second stage is the code register that feeds the converter. This split lets the host stage new codes on several channels and then apply them all in one step.

The same words also control three other things: a general-purpose logic output, a shutdown flag, and the clock edge used by the serial echo output. The echo output lets several of these cores share one data line in a chain. A power-on reset and an active-low clear both return the core to its default state. A lockout input controls shutdown. It must be high for the core to enter shutdown, and pulling it low while in shutdown wakes the core.

The serial pins, the clear and the lockout pin are sampled by the block clock. The serial clock must therefore run well below the block clock, and edges on those pins are found by comparing each sample with the one before it.

Top module: `sdac_core`

## Requirements
- R1: A frame is shifted in MSB first. A bit of `din` is taken only on a sampled rising edge of `sclk` while `cs_n` is low. In the 16-bit word, bits [15:14] are the channel address (0 to 3), bits [13:12] are the control bits, bits [11:2] are the 10-bit code, and bits [1:0] are sub-bits that are never stored. The opcode is bits [15:12].
- R2: A command runs on the sampled rising edge of `cs_n`. It uses the 16 most recently shifted bits, whatever number of clocks the frame held.
- R3: Opcode `cc01` loads the staging register of channel `cc`. All code registers stay unchanged.
- R4: Opcode `cc11` loads the staging register of channel `cc`. Every code register then takes its staging value, including the value just loaded.
- R5: Opcode 0100 copies every staging register into its code register and leaves shutdown.
- R6: Opcode 1000 writes the frame's code into all staging and all code registers and leaves shutdown.
- R7: Opcode 1100 sets `shutdown` only when `sleep_allow` is high. Shutdown changes no register contents, and frames received during shutdown are still executed.
- R8: Opcode 0010 drives `user_out` low and opcode 0110 drives it high. Opcode 0000 changes nothing.
- R9: Opcode 1010 selects rising-edge echo and opcode 1110 selects falling-edge echo. Both copy every staging register into its code register.
- R10: `echo_out` carries the bit that was shifted in 16 rising edges earlier. In rising-edge mode it changes on the rising `sclk` edge. In falling-edge mode it changes on the next falling `sclk` edge, which adds half a serial clock of lag. Falling-edge mode is the default.
- R11: Reset, or `clr_n` sampled low, clears every staging and code register, `user_out`, `echo_out`, the shift contents and `shutdown`, and selects falling-edge mode. In the same cycle the clear wins over any command.
- R12: While `shutdown` is set, a sampled high-to-low transition of `sleep_allow` clears it. The code registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| clr_n | input | 1 | Active-low clear, sampled by `clk` |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| cs_n | input | 1 | Active-low frame select; its rising edge executes the frame |
| din | input | 1 | Serial data in |
| sleep_allow | input | 1 | High permits shutdown; a falling edge wakes from shutdown |
| dac_code | output | 40 | Four 10-bit code registers; channel n occupies bits [10n+9:10n] |
| shutdown | output | 1 | Shutdown flag |
| user_out | output | 1 | General-purpose logic output |
| echo_out | output | 1 | Serial echo of the shift register's far end |

## Verification
The properties assume a well-behaved serial port. Each `sclk` level must last at least one block clock, `sclk` must not toggle in the cycle where `cs_n` rises, and the clear and lockout pins must be settled values sampled on the block clock. The bench meets these assumptions by design. It changes every input just after a falling `clk` edge, holds each `sclk` phase for two block clocks, and surrounds the `cs_n` edges with idle cycles. Its random phase mixes all sixteen opcodes with random codes and sub-bits, frames of 12, 16 and 20 bits, lockout toggles and clear pulses. This lets the cycle-accurate model exercise shutdown, wake and echo-mode changes in many orderings.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int ADDR_W  = 2;
    localparam int CTRL_W  = 2;
    localparam int CODE_W  = 10;
    localparam int SUB_W   = 2;
    localparam int OP_W    = ADDR_W + CTRL_W;
    localparam int FRAME_W = OP_W + CODE_W + SUB_W;
    localparam int BODY_W  = FRAME_W - SUB_W;
    localparam int NCH     = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] chan_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [OP_W-1:0]   op_t;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } echo_edge_e;

    typedef struct packed {
        logic  load_one;
        logic  load_all;
        logic  copy_all;
        logic  sd_enter;
        logic  sd_exit;
        logic  upo_set;
        logic  upo_val;
        logic  mode_set;
        logic  mode_val;
        chan_t chan;
        code_t code;
    } cmd_t;

    function automatic op_t body_op(input logic [BODY_W-1:0] body);
        return body[BODY_W-1 -: OP_W];
    endfunction

    function automatic chan_t body_chan(input logic [BODY_W-1:0] body);
        return body[BODY_W-1 -: ADDR_W];
    endfunction

    function automatic code_t body_code(input logic [BODY_W-1:0] body);
        return body[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
#(
    parameter int WIDTH = FRAME_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             din,
    input  echo_edge_e       echo_edge,
    output logic [WIDTH-1:0] frame,
    output logic             frame_done,
    output logic             echo_out
);

    logic             sclk_q;
    logic             cs_q;
    logic             sclk_rise;
    logic             sclk_fall;
    logic [WIDTH-1:0] shift_q;
    logic             fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    assign sclk_rise  = sclk && !sclk_q;
    assign sclk_fall  = !sclk && sclk_q;
    assign frame_done = cs_n && !cs_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            shift_q <= '0;
        end else if (sclk_rise && !cs_n) begin
            shift_q <= {shift_q[WIDTH-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fall_q <= 1'b0;
        end else if (sclk_fall) begin
            fall_q <= shift_q[WIDTH-1];
        end
    end

    assign frame    = shift_q;
    assign echo_out = (echo_edge == EDGE_RISE) ? shift_q[WIDTH-1] : fall_q;

endmodule

// File: rtl/sdac_decoder.sv
module sdac_decoder
    import sdac_pkg::*;
(
    input  logic [BODY_W-1:0] body,
    output cmd_t              cmd
);

    op_t op;

    assign op = body_op(body);

    always_comb begin
        cmd      = '0;
        cmd.chan = body_chan(body);
        cmd.code = body_code(body);
        if (op[0]) begin
            cmd.load_one = 1'b1;
            cmd.copy_all = op[1];
        end else begin
            case ({op[3:2], op[1]})
                3'b000: ;
                3'b001: begin
                    cmd.upo_set = 1'b1;
                    cmd.upo_val = 1'b0;
                end
                3'b010: begin
                    cmd.copy_all = 1'b1;
                    cmd.sd_exit  = 1'b1;
                end
                3'b011: begin
                    cmd.upo_set = 1'b1;
                    cmd.upo_val = 1'b1;
                end
                3'b100: begin
                    cmd.load_all = 1'b1;
                    cmd.sd_exit  = 1'b1;
                end
                3'b101: begin
                    cmd.mode_set = 1'b1;
                    cmd.mode_val = 1'b1;
                    cmd.copy_all = 1'b1;
                end
                3'b110: cmd.sd_enter = 1'b1;
                default: begin
                    cmd.mode_set = 1'b1;
                    cmd.mode_val = 1'b0;
                    cmd.copy_all = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdac_regbank.sv
module sdac_regbank
    import sdac_pkg::*;
#(
    parameter int CHANNELS = NCH,
    parameter int CW       = CODE_W,
    parameter int AW       = ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   fire,
    input  logic                   load_one,
    input  logic                   load_all,
    input  logic                   copy_all,
    input  logic [AW-1:0]          load_chan,
    input  logic [CW-1:0]          load_code,
    output logic [CHANNELS*CW-1:0] dac_code
);

    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
        logic [CW-1:0] stage_q;
        logic [CW-1:0] live_q;
        logic          hit;

        assign hit = load_one && (load_chan == AW'(i));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                stage_q <= '0;
                live_q  <= '0;
            end else if (fire) begin
                if (hit || load_all) begin
                    stage_q <= load_code;
                end
                if (load_all) begin
                    live_q <= load_code;
                end else if (copy_all) begin
                    live_q <= hit ? load_code : stage_q;
                end
            end
        end

        assign dac_code[i*CW +: CW] = live_q;
    end

endmodule

// File: rtl/sdac_core.sv
module sdac_core
    import sdac_pkg::*;
#(
    parameter int CHANNELS = NCH,
    parameter int CW       = CODE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr_n,
    input  logic                   sclk,
    input  logic                   cs_n,
    input  logic                   din,
    input  logic                   sleep_allow,
    output logic [CHANNELS*CW-1:0] dac_code,
    output logic                   shutdown,
    output logic                   user_out,
    output logic                   echo_out
);

    logic               clear;
    logic [FRAME_W-1:0] frame_q;
    logic               frame_done;
    logic               fire;
    cmd_t               cmd;
    echo_edge_e         edge_q;
    logic               upo_q;
    logic               sd_q;
    logic               allow_q;
    logic               wake;

    assign clear = !clr_n;
    assign fire  = frame_done && !clear;

    sdac_shifter #(.WIDTH(FRAME_W)) shifter_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .din        (din),
        .echo_edge  (edge_q),
        .frame      (frame_q),
        .frame_done (frame_done),
        .echo_out   (echo_out)
    );

    sdac_decoder decoder_i (
        .body (frame_q[FRAME_W-1:SUB_W]),
        .cmd  (cmd)
    );

    sdac_regbank #(.CHANNELS(CHANNELS), .CW(CW), .AW(ADDR_W)) regbank_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .fire      (fire),
        .load_one  (cmd.load_one),
        .load_all  (cmd.load_all),
        .copy_all  (cmd.copy_all),
        .load_chan (cmd.chan),
        .load_code (cmd.code),
        .dac_code  (dac_code)
    );

    assign wake = sd_q && allow_q && !sleep_allow;

    always_ff @(posedge clk) begin
        if (rst) begin
            allow_q <= 1'b0;
        end else begin
            allow_q <= sleep_allow;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            edge_q <= EDGE_FALL;
            upo_q  <= 1'b0;
            sd_q   <= 1'b0;
        end else begin
            if (wake) begin
                sd_q <= 1'b0;
            end
            if (fire) begin
                if (cmd.mode_set) begin
                    edge_q <= cmd.mode_val ? EDGE_RISE : EDGE_FALL;
                end
                if (cmd.upo_set) begin
                    upo_q <= cmd.upo_val;
                end
                if (cmd.sd_exit) begin
                    sd_q <= 1'b0;
                end else if (cmd.sd_enter && sleep_allow) begin
                    sd_q <= 1'b1;
                end
            end
        end
    end

    assign shutdown = sd_q;
    assign user_out = upo_q;

endmodule

// File: rtl/sdac_core_chk.sv
module sdac_core_chk
    import sdac_pkg::*;
#(
    parameter int CHANNELS = NCH,
    parameter int CW       = CODE_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   clr_n,
    input logic                   cs_n,
    input logic                   sleep_allow,
    input logic                   frame_done,
    input logic [FRAME_W-1:0]     frame_q,
    input logic [CHANNELS*CW-1:0] dac_code,
    input logic                   shutdown,
    input logic                   user_out,
    input logic                   echo_out
);

    assert_frame_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (cs_n && clr_n) |=> $stable(frame_q));

    assert_code_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!frame_done && clr_n) |=> $stable(dac_code));

    assert_broadcast_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_done && clr_n && frame_q[FRAME_W-1 -: OP_W] == 4'b1000)
        |=> (dac_code == {CHANNELS{$past(frame_q[SUB_W +: CW])}}));

    assert_sleep_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (!shutdown && !sleep_allow) |=> !shutdown);

    assert_upo_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!frame_done && clr_n) |=> $stable(user_out));

    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (dac_code == '0 && !user_out && !echo_out && !shutdown));

    assert_wake_R12: assert property (@(posedge clk) disable iff (rst)
        (shutdown && $fell(sleep_allow) && clr_n) |=> (!shutdown && $stable(dac_code)));

endmodule

bind sdac_core sdac_core_chk #(.CHANNELS(CHANNELS), .CW(CW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .clr_n       (clr_n),
    .cs_n        (cs_n),
    .sleep_allow (sleep_allow),
    .frame_done  (frame_done),
    .frame_q     (frame_q),
    .dac_code    (dac_code),
    .shutdown    (shutdown),
    .user_out    (user_out),
    .echo_out    (echo_out)
);

// File: tb/sdac_core_tb_top.sv
module sdac_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        sleep_allow = 1'b0;
    logic [39:0] dac_code;
    logic        shutdown;
    logic        user_out;
    logic        echo_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sdac_core dut_i (
        .clk         (clk),
        .rst         (rst),
        .clr_n       (clr_n),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .din         (din),
        .sleep_allow (sleep_allow),
        .dac_code    (dac_code),
        .shutdown    (shutdown),
        .user_out    (user_out),
        .echo_out    (echo_out)
    );

    // behavioural reference model
    int m_stage[4];
    int m_live[4];
    bit m_upo, m_rise_mode, m_sd, m_fallcap;
    bit hist[$];
    bit p_sclk, p_cs, p_allow;

    function automatic void model_clear();
        for (int c = 0; c < 4; c++) begin
            m_stage[c] = 0;
            m_live[c]  = 0;
        end
        m_upo = 0; m_rise_mode = 0; m_sd = 0; m_fallcap = 0;
        hist.delete();
        for (int k = 0; k < 16; k++) hist.push_back(1'b0);
    endfunction

    function automatic void model_exec(input int word);
        int op   = (word >> 12) & 15;
        int code = (word >> 2) & 1023;
        if (op % 2 == 1) begin
            m_stage[op / 4] = code;
            if ((op / 2) % 2 == 1)
                for (int c = 0; c < 4; c++) m_live[c] = m_stage[c];
        end else begin
            case (op)
                2:  m_upo = 0;
                6:  m_upo = 1;
                4:  begin for (int c = 0; c < 4; c++) m_live[c] = m_stage[c]; m_sd = 0; end
                8:  begin for (int c = 0; c < 4; c++) begin m_stage[c] = code; m_live[c] = code; end m_sd = 0; end
                10: begin m_rise_mode = 1; for (int c = 0; c < 4; c++) m_live[c] = m_stage[c]; end
                14: begin m_rise_mode = 0; for (int c = 0; c < 4; c++) m_live[c] = m_stage[c]; end
                12: if (sleep_allow) m_sd = 1;
                default: ;
            endcase
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            model_clear();
            p_sclk = 0; p_cs = 1; p_allow = 0;
        end else begin
            bit rise, fall, csr, afell;
            int word;
            rise  = sclk && !p_sclk;
            fall  = !sclk && p_sclk;
            csr   = cs_n && !p_cs;
            afell = !sleep_allow && p_allow;
            word  = 0;
            for (int k = 0; k < 16; k++) word = (word << 1) | int'(hist[k]);
            if (!clr_n) begin
                model_clear();
            end else begin
                if (fall) m_fallcap = hist[0];
                if (rise && !cs_n) begin
                    void'(hist.pop_front());
                    hist.push_back(din);
                end
                if (afell && m_sd) m_sd = 0;
                if (csr) model_exec(word);
            end
            p_sclk = sclk; p_cs = cs_n; p_allow = sleep_allow;
        end
    end

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [39:0] exp_dac;
            for (int c = 0; c < 4; c++) exp_dac[c*10 +: 10] = 10'(m_live[c]);
            chk("R4 model dac_code", dac_code, exp_dac);
            chk("R7 model shutdown", 40'(shutdown), 40'(m_sd));
            chk("R8 model user_out", 40'(user_out), 40'(m_upo));
            chk("R10 model echo_out", 40'(echo_out), 40'(m_rise_mode ? hist[0] : m_fallcap));
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        cs_n = 1'b0;
        wait_clk(2);
        for (int k = n - 1; k >= 0; k--) begin
            din = w[k];
            wait_clk(2);
            sclk = 1'b1;
            wait_clk(2);
            sclk = 1'b0;
        end
        wait_clk(2);
        cs_n = 1'b1;
        wait_clk(3);
    endtask

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [9:0] code, input logic [1:0] sub);
        return {op, code, sub};
    endfunction

    function automatic logic [39:0] pack4(input logic [9:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R11 reset state
        chk("R11 reset dac_code", dac_code, '0);
        chk("R11 reset user_out", 40'(user_out), 0);
        chk("R11 reset echo_out", 40'(echo_out), 0);
        chk("R11 reset shutdown", 40'(shutdown), 0);

        // R3 staging load with sub-bits set (R1 ignores them)
        send_bits(32'(mk(4'b0001, 10'h155, 2'b11)), 16);
        chk("R3 load A only", dac_code, '0);
        // R4 load B and apply all
        send_bits(32'(mk(4'b0111, 10'h2AA, 2'b10)), 16);
        chk("R4 load B and update", dac_code, pack4(10'h155, 10'h2AA, 0, 0));
        chk("R1 sub-bits not stored", 40'(dac_code[9:0]), 40'h155);
        send_bits(32'(mk(4'b1001, 10'h0F0, 2'b00)), 16);
        send_bits(32'(mk(4'b1101, 10'h3FF, 2'b00)), 16);
        chk("R3 C and D staged only", dac_code, pack4(10'h155, 10'h2AA, 0, 0));
        send_bits(32'(mk(4'b0100, 10'h000, 2'b00)), 16);
        chk("R5 copy all", dac_code, pack4(10'h155, 10'h2AA, 10'h0F0, 10'h3FF));
        chk("R10 echo after frame", 40'(echo_out), 0);

        // R8 user output and no-op
        send_bits(32'(mk(4'b0110, 10'h3FF, 2'b11)), 16);
        chk("R8 upo high", 40'(user_out), 1);
        send_bits(32'(mk(4'b0000, 10'h3FF, 2'b11)), 16);
        chk("R8 nop user_out", 40'(user_out), 1);
        chk("R8 nop dac_code", dac_code, pack4(10'h155, 10'h2AA, 10'h0F0, 10'h3FF));
        send_bits(32'(mk(4'b0010, 10'h000, 2'b00)), 16);
        chk("R8 upo low", 40'(user_out), 0);

        // R7 shutdown gated by lockout
        send_bits(32'(mk(4'b1100, 10'h000, 2'b00)), 16);
        chk("R7 locked out", 40'(shutdown), 0);
        sleep_allow = 1'b1;
        wait_clk(2);
        send_bits(32'(mk(4'b1100, 10'h000, 2'b00)), 16);
        chk("R7 shutdown entered", 40'(shutdown), 1);
        send_bits(32'(mk(4'b0001, 10'h001, 2'b00)), 16);
        chk("R7 codes kept in shutdown", dac_code, pack4(10'h155, 10'h2AA, 10'h0F0, 10'h3FF));
        send_bits(32'(mk(4'b0100, 10'h000, 2'b00)), 16);
        chk("R5 exit shutdown", 40'(shutdown), 0);
        chk("R7 load during shutdown applied", dac_code, pack4(10'h001, 10'h2AA, 10'h0F0, 10'h3FF));

        // R12 wake by lockout fall
        send_bits(32'(mk(4'b1100, 10'h000, 2'b00)), 16);
        chk("R12 asleep", 40'(shutdown), 1);
        sleep_allow = 1'b0;
        wait_clk(2);
        chk("R12 woken", 40'(shutdown), 0);
        chk("R12 codes kept", dac_code, pack4(10'h001, 10'h2AA, 10'h0F0, 10'h3FF));

        // R6 broadcast leaves shutdown
        sleep_allow = 1'b1;
        wait_clk(2);
        send_bits(32'(mk(4'b1100, 10'h000, 2'b00)), 16);
        send_bits(32'(mk(4'b1000, 10'h2C3, 2'b01)), 16);
        chk("R6 broadcast", dac_code, pack4(10'h2C3, 10'h2C3, 10'h2C3, 10'h2C3));
        chk("R6 exit shutdown", 40'(shutdown), 0);

        // R2 long frame: only last 16 bits count
        send_bits({12'h000, 4'b1011, mk(4'b0011, 10'h111, 2'b00)}, 20);
        chk("R2 long frame", dac_code, pack4(10'h111, 10'h2C3, 10'h2C3, 10'h2C3));

        // R9 edge mode commands update codes
        send_bits(32'(mk(4'b0101, 10'h123, 2'b00)), 16);
        send_bits(32'(mk(4'b1010, 10'h000, 2'b00)), 16);
        chk("R9 rise mode update", dac_code, pack4(10'h111, 10'h123, 10'h2C3, 10'h2C3));
        chk("R10 rise mode echo", 40'(echo_out), 1);
        send_bits(32'(mk(4'b1110, 10'h000, 2'b00)), 16);
        chk("R9 fall mode echo", 40'(echo_out), 1);

        // R11 clear
        clr_n = 1'b0;
        wait_clk(1);
        clr_n = 1'b1;
        wait_clk(1);
        chk("R11 clear dac_code", dac_code, '0);
        chk("R11 clear echo_out", 40'(echo_out), 0);

        // random phase, compared every cycle by the model
        for (int n = 0; n < 400; n++) begin
            int len;
            logic [31:0] w;
            len = 16;
            if ($urandom_range(0, 9) == 0) len = 20;
            if ($urandom_range(0, 9) == 0) len = 12;
            w = $urandom;
            if ($urandom_range(0, 4) == 0) begin
                sleep_allow = ~sleep_allow;
                wait_clk(2);
            end
            if ($urandom_range(0, 39) == 0) begin
                clr_n = 1'b0;
                wait_clk(1);
                clr_n = 1'b1;
                wait_clk(1);
            end
            send_bits(w, len);
        end

        wait_clk(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule